// File: doc/BRIEF.md
# Triple Wiper Position Register Bank

This block keeps the wiper settings of three digitally controlled resistor arrays. Each array has two registers. The working register drives the wiper output. The backing register stands in for non-volatile storage and is built from ordinary flops. A single write port carries a strobe, a two-bit array code, a write-type flag and an eight-bit value. The write-type flag chooses between changing only the working register and changing both registers.

Every value is clamped to the top tap of the array it targets before it is stored, so a value that is too large never wraps around. The arrays have 64, 100 and 256 taps. A restore pulse models a power cycle: it copies each backing register into its working register, which discards any setting that was written to the working register only. The array code 11 is reserved, and a write that uses it is dropped.

Top module: `wiper_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, the working and backing registers of all three arrays clear to 0, so all three wiper outputs read 0 after that edge.
- R2: A write with `wr_sel` = 00, 01 or 10 updates array 0, 1 or 2 respectively and leaves the other two arrays unchanged.
- R3: A write with `wr_sel` = 11 changes no working or backing register.
- R4: Array 0 has 64 taps. A written value up to 3Fh is stored unchanged, and any larger value stores 3Fh (63).
- R5: Array 1 has 100 taps. The written value is taken as a tap index: values up to 63h (99) are stored unchanged, and any larger value stores 63h.
- R6: Array 2 has 256 taps. Every value from 00h to FFh is stored unchanged, so the value equals the tap number.
- R7: A write with `wr_nv` = 0 updates only the working register. The backing register keeps its previous contents.
- R8: A write with `wr_nv` = 1 stores the clamped value in both the working register and the backing register of the selected array.
- R9: A `restore` pulse loads every working register from its backing register.
- R10: When `restore` and `wr_en` are high in the same cycle, the restore takes effect and the write is discarded.
- R11: A wiper output changes only on the clock edge that takes the write or restore, and the new value is visible immediately after that edge. With no write or restore, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_sel | input | 2 | Array code (00, 01 and 10 select an array; 11 is reserved) |
| wr_nv | input | 1 | Write type: 0 updates the working register only, 1 also updates the backing register |
| wr_data | input | 8 | Requested tap value |
| restore | input | 1 | Power-up restore pulse |
| wiper0_o | output | 8 | Current tap of array 0 |
| wiper1_o | output | 8 | Current tap of array 1 |
| wiper2_o | output | 8 | Current tap of array 2 |

## Verification
The bench builds the block with its default tap counts of 64, 100 and 256. This covers three different clamp conditions in one run: a power-of-two limit below the data range, a limit that is not a power of two, and a limit equal to the full eight-bit range, where no clamping happens. With an eight-bit data path, random values regularly land above 3Fh and above 63h, so the saturation paths are exercised well beyond the directed edge values. Random restores are mixed in with working-only and backing writes, which tests again and again that working-only writes are lost on restore.

// File: rtl/wiper_pkg.sv
// Shared constants and types for the wiper register bank.
// Assumes three arrays addressed by a two-bit code, with the top code reserved.
package wiper_pkg;
    localparam int DATA_W  = 8;
    localparam int SEL_W   = 2;
    localparam int NUM_ARR = 3;

    typedef logic [DATA_W-1:0] tap_t;
endpackage

// File: rtl/wiper_decode.sv
// Turns the array code into one write enable per array.
// Assumes that restore takes priority, so no enable is raised during a restore.
// A reserved code raises no enable.
module wiper_decode
    import wiper_pkg::*;
(
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic               restore,
    output logic [NUM_ARR-1:0] wr_vec
);
    // Purpose: raise the enable of the addressed array when it exists.
    always_comb begin
        wr_vec = '0;
        for (int i = 0; i < NUM_ARR; i++) begin
            if (wr_en && !restore && (wr_sel == SEL_W'(i)))
                wr_vec[i] = 1'b1;
        end
    end
endmodule

// File: rtl/wiper_clamp.sv
// Saturates a requested tap value at the highest tap of one array.
// Assumes TAPS is between 1 and 2**DATA_W.
module wiper_clamp
    import wiper_pkg::*;
#(
    parameter int TAPS = 64
) (
    input  tap_t din,
    output tap_t dout
);
    localparam tap_t TOP = tap_t'(TAPS - 1);

    // Purpose: pass the value through unless it is above the top tap.
    always_comb begin
        dout = (din > TOP) ? TOP : din;
    end
endmodule

// File: rtl/wiper_cell.sv
// Working and backing register pair for one array.
// Assumes the write data is already clamped and that the write enable is low during a restore.
module wiper_cell
    import wiper_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wr_nv,
    input  tap_t din,
    input  logic restore,
    output tap_t vol_q
);
    tap_t nv_q;

    // Purpose: clear on reset, then apply a restore or a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_q <= '0;
            nv_q  <= '0;
        end else if (restore) begin
            vol_q <= nv_q;
        end else if (wr) begin
            vol_q <= din;
            if (wr_nv)
                nv_q <= din;
        end
    end

    AST_RESTORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (vol_q == $past(nv_q))); // R9
    AST_NV_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && wr_nv) |=> $stable(nv_q)); // R7
    AST_VOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !restore) |=> $stable(vol_q)); // R11
endmodule

// File: rtl/wiper_bank.sv
// Top level of the bank: decode, clamp and store for three arrays.
// Assumes that one write at most arrives per cycle and that restore overrides a write.
module wiper_bank
    import wiper_pkg::*;
#(
    parameter int TAPS0 = 64,
    parameter int TAPS1 = 100,
    parameter int TAPS2 = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              wr_nv,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              restore,
    output logic [DATA_W-1:0] wiper0_o,
    output logic [DATA_W-1:0] wiper1_o,
    output logic [DATA_W-1:0] wiper2_o
);
    logic [NUM_ARR-1:0] wr_vec;
    tap_t               clamped [NUM_ARR];
    tap_t               vol     [NUM_ARR];

    wiper_decode u_dec (
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .restore (restore),
        .wr_vec  (wr_vec)
    );

    for (genvar g = 0; g < NUM_ARR; g++) begin : g_arr
        localparam int T = (g == 0) ? TAPS0 : (g == 1) ? TAPS1 : TAPS2;

        wiper_clamp #(.TAPS(T)) u_clamp (
            .din  (wr_data),
            .dout (clamped[g])
        );

        wiper_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (wr_vec[g]),
            .wr_nv   (wr_nv),
            .din     (clamped[g]),
            .restore (restore),
            .vol_q   (vol[g])
        );
    end

    assign wiper0_o = vol[0];
    assign wiper1_o = vol[1];
    assign wiper2_o = vol[2];

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec)); // R2
    AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b11 && !restore) |=>
        ($stable(wiper0_o) && $stable(wiper1_o) && $stable(wiper2_o))); // R3
    AST_TOP0: assert property (@(posedge clk) disable iff (!rst_n)
        wiper0_o <= tap_t'(TAPS0 - 1)); // R4
    AST_TOP1: assert property (@(posedge clk) disable iff (!rst_n)
        wiper1_o <= tap_t'(TAPS1 - 1)); // R5
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (wiper0_o == '0 && wiper1_o == '0 && wiper2_o == '0)); // R1
endmodule

// File: tb/wiper_bank_tb.sv
module wiper_bank_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, wr_nv, restore;
    logic [1:0] wr_sel;
    logic [7:0] wr_data;
    logic [7:0] wiper0_o, wiper1_o, wiper2_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] m_vol [3];
    logic [7:0] m_nv  [3];

    always #5 clk = ~clk;

    wiper_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_nv(wr_nv),
        .wr_data(wr_data), .restore(restore),
        .wiper0_o(wiper0_o), .wiper1_o(wiper1_o), .wiper2_o(wiper2_o)
    );

    function automatic logic [7:0] top_of(int a);
        return (a == 0) ? 8'd63 : (a == 1) ? 8'd99 : 8'd255;
    endfunction

    function automatic logic [7:0] clampv(int a, logic [7:0] d);
        return (d > top_of(a)) ? top_of(a) : d;
    endfunction

    task automatic check_all(string req);
        logic [7:0] got [3];
        got[0] = wiper0_o;
        got[1] = wiper1_o;
        got[2] = wiper2_o;
        for (int i = 0; i < 3; i++) begin
            checks++;
            if (got[i] !== m_vol[i]) begin
                errors++;
                $display("FAIL %s wiper%0d actual %0d expected %0d", req, i, got[i], m_vol[i]);
            end
        end
    endtask

    // Drive one cycle at the falling edge, update the model and check at the next falling edge.
    task automatic step(logic w, logic [1:0] s, logic n, logic [7:0] d, logic r, string req);
        wr_en = w; wr_sel = s; wr_nv = n; wr_data = d; restore = r;
        #1 check_all({req, " before edge"}); // R11: no change before the edge
        if (r) begin
            for (int i = 0; i < 3; i++) m_vol[i] = m_nv[i];
        end else if (w && s != 2'b11) begin
            m_vol[s] = clampv(int'(s), d);
            if (n) m_nv[s] = clampv(int'(s), d);
        end
        @(negedge clk);
        check_all(req);
        wr_en = 0; restore = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; wr_en = 0; wr_sel = 0; wr_nv = 0; wr_data = 0; restore = 0;
        for (int i = 0; i < 3; i++) begin m_vol[i] = 0; m_nv[i] = 0; end
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1;
        @(negedge clk);

        step(1, 2'b00, 0, 8'h0F, 0, "R4 exact tap");
        step(1, 2'b00, 0, 8'h3F, 0, "R4 top tap");
        step(1, 2'b00, 0, 8'h40, 0, "R4 saturate");
        step(1, 2'b00, 0, 8'hFF, 0, "R4 saturate max");
        step(1, 2'b01, 0, 8'h63, 0, "R5 top tap");
        step(1, 2'b01, 0, 8'h64, 0, "R5 saturate");
        step(1, 2'b01, 0, 8'h20, 0, "R5 exact");
        step(1, 2'b10, 0, 8'hFF, 0, "R6 full range");
        step(1, 2'b10, 0, 8'h00, 0, "R6 zero");
        step(1, 2'b11, 1, 8'h55, 0, "R3 reserved");
        step(1, 2'b10, 1, 8'h10, 0, "R8 backing write");
        step(1, 2'b10, 0, 8'h80, 0, "R7 working only");
        step(0, 2'b00, 0, 8'h00, 1, "R9 restore R7");
        step(1, 2'b00, 1, 8'h70, 0, "R8 saturate both");
        step(0, 2'b00, 0, 8'h00, 1, "R9 restore R8");
        step(1, 2'b01, 1, 8'h05, 1, "R10 restore wins");
        step(0, 2'b00, 0, 8'h00, 1, "R10 backing untouched");
        step(0, 2'b01, 1, 8'h33, 0, "R11 idle hold");
        step(1, 2'b01, 0, 8'h07, 0, "R2 array1 only");

        void'($urandom(32'd2024));
        for (int k = 0; k < 400; k++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(rv[0] | rv[1], rv[3:2], rv[4], rv[15:8], (rv[7:5] == 3'd0), "R2 random");
        end

        rst_n = 0;
        for (int i = 0; i < 3; i++) begin m_vol[i] = 0; m_nv[i] = 0; end
        @(negedge clk);
        rst_n = 1;
        check_all("R1 second reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule